// File: doc/BRIEF.md
# PCI Clock Stop Gating

This block sits between the clock sources of a system clock generator and its PCI-class output pins. It takes a 33 MHz source and a 66 MHz source and produces a bank of gated 33 MHz PCI clocks, one dedicated PCI clock that never stops, and a group of shared outputs. Each shared output carries either 33 MHz or 66 MHz, chosen by a per-output select that comes from the power-up strap logic. An active-low stop request, per-output enable bits and per-output stop-immunity bits decide which outputs run at any moment.

Every output has its own gate cell. The cell samples the output's run request on falling edges of that output's own source clock, through a short synchronizer. The gate therefore opens or closes only while the source is low. A stopped or disabled output parks low, and every high phase it drives is a full half period, so no runt pulses occur. The stop request acts only when the strap logic has configured the stop pin as an input. The 66 MHz selects must stay fixed while the block is out of reset.

Top module: `pcg_clock_gater`

## Requirements
- R1: While `rst_ni` is low every output is low. After release, an output first goes high on the first rising edge of its source that follows the SYNC_STAGES-th falling edge of that source after release.
- R2: With `stop_strap_i`=1, `stop_ni`=0 holds low every PCI output whose immunity bit is not 1. `stop_ni`=1 lets every enabled PCI output run.
- R3: `pcif_clk_o` runs whenever `pcif_en_i`=1, whatever the stop controls. It is held low when `pcif_en_i`=0.
- R4: A shared output with `sel66_i` bit =1 runs from the 66 MHz source and keeps running during a stop. A shared output with its bit =0 runs from the 33 MHz source and is stopped like a PCI output.
- R5: `pci_free_i` bit k gives stop immunity to PCI output FREE_BASE+k (default indices 3, 4 and 5). Other PCI outputs have no immunity.
- R6: An enable bit of 0 (in `pci_en_i`, `shr_en_i` or `pcif_en_i`) holds its output low, regardless of stop and immunity. A 1 enables the output.
- R7: With `stop_strap_i`=0, `stop_ni` has no effect on any output.
- R8: A gate opens or closes only while its source clock is low. Every high pulse on an output lasts exactly half a period of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_33_i | input | 1 | 33 MHz source clock |
| clk_66_i | input | 1 | 66 MHz source clock, rising edges aligned with clk_33_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_strap_i | input | 1 | 1 = stop pin configured as stop input |
| stop_ni | input | 1 | Active-low stop request |
| sel66_i | input | N_SHR | Per shared output: 1 = 66 MHz, 0 = 33 MHz (static) |
| pci_en_i | input | N_PCI | PCI output enables, 1 = enabled |
| pci_free_i | input | N_FREE | Stop immunity for PCI outputs FREE_BASE upward |
| shr_en_i | input | N_SHR | Shared output enables, 1 = enabled |
| pcif_en_i | input | 1 | Dedicated free-running output enable |
| pci_clk_o | output | N_PCI | Gated 33 MHz PCI clocks |
| shr_clk_o | output | N_SHR | Gated shared 33/66 MHz clocks |
| pcif_clk_o | output | 1 | Dedicated free-running PCI clock |

## Verification
The bench builds the block with eight PCI outputs, four shared outputs, the immunity window at indices 3 to 5 and a two-stage synchronizer. It ties the 66 MHz selects to 0101. This mix puts stop-immune and stoppable PCI outputs next to each other on both sides of the window, and places a 33 MHz and a 66 MHz shared output side by side under the same stop. It also makes the reset-release latency span two full source phases, long enough to see. Control changes are applied in the middle of a high phase, so a gate that closed early would cut a pulse short.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    // Source choice of a shared output; the select bit value is the encoding.
    typedef enum logic {
        SRC_33 = 1'b0,
        SRC_66 = 1'b1
    } pcg_src_e;

    // True when PCI index idx falls inside the stop-immunity window.
    function automatic logic pcg_in_window(int unsigned idx, int unsigned base, int unsigned cnt);
        return (idx >= base) && (idx < base + cnt);
    endfunction

    // An output is held by a stop unless it is immune to it.
    function automatic logic pcg_hold(logic stop_act, logic immune);
        return stop_act & ~immune;
    endfunction

endpackage

// File: rtl/pcg_req_map.sv
module pcg_req_map
    import pcg_pkg::*;
#(
    parameter int unsigned N_PCI     = 8,
    parameter int unsigned N_SHR     = 4,
    parameter int unsigned FREE_BASE = 3,
    parameter int unsigned N_FREE    = 3
) (
    input  logic              stop_strap_i,
    input  logic              stop_ni,
    input  logic [N_SHR-1:0]  sel66_i,
    input  logic [N_PCI-1:0]  pci_en_i,
    input  logic [N_FREE-1:0] pci_free_i,
    input  logic [N_SHR-1:0]  shr_en_i,
    input  logic              pcif_en_i,
    output logic [N_PCI-1:0]  pci_req_o,
    output logic [N_SHR-1:0]  shr_req_o,
    output logic              pcif_req_o
);

    typedef struct packed {
        logic [N_PCI-1:0] pci;
        logic [N_SHR-1:0] shr;
        logic             pcif;
    } req_t;

    logic             stop_act;
    logic [N_PCI-1:0] immune;
    req_t             req_d;

    // Stop is only meaningful when the pin is strapped as the stop input.
    assign stop_act = stop_strap_i & ~stop_ni;

    for (genvar i = 0; i < N_PCI; i++) begin : g_imm
        if (pcg_in_window(i, FREE_BASE, N_FREE)) begin : g_win
            assign immune[i] = pci_free_i[i - FREE_BASE];
        end else begin : g_fix
            assign immune[i] = 1'b0;
        end
    end

    always_comb begin
        req_d = '0;
        for (int i = 0; i < N_PCI; i++) begin
            req_d.pci[i] = pci_en_i[i] & ~pcg_hold(stop_act, immune[i]);
        end
        for (int j = 0; j < N_SHR; j++) begin
            req_d.shr[j] = shr_en_i[j] & ~pcg_hold(stop_act, pcg_src_e'(sel66_i[j]) == SRC_66);
        end
        req_d.pcif = pcif_en_i;
    end

    assign pci_req_o  = req_d.pci;
    assign shr_req_o  = req_d.shr;
    assign pcif_req_o = req_d.pcif;

endmodule

// File: rtl/pcg_gate_cell.sv
module pcg_gate_cell #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic src_clk_i,
    input  logic rst_ni,
    input  logic run_req_i,
    output logic gate_o,
    output logic clk_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } cell_t;

    cell_t st_d, st_q;

    if (SYNC_STAGES == 1) begin : g_one
        always_comb begin
            st_d       = st_q;
            st_d.chain = run_req_i;
        end
    end else begin : g_many
        always_comb begin
            st_d       = st_q;
            st_d.chain = {st_q.chain[SYNC_STAGES-2:0], run_req_i};
        end
    end

    // Falling-edge sampling: the gate only moves while the source is low.
    always_ff @(negedge src_clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign gate_o = st_q.chain[LAST];
    assign clk_o  = src_clk_i & gate_o;

endmodule

// File: rtl/pcg_clock_gater.sv
module pcg_clock_gater
    import pcg_pkg::*;
#(
    parameter int unsigned N_PCI       = 8,
    parameter int unsigned N_SHR       = 4,
    parameter int unsigned FREE_BASE   = 3,
    parameter int unsigned N_FREE      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_33_i,
    input  logic              clk_66_i,
    input  logic              rst_ni,
    input  logic              stop_strap_i,
    input  logic              stop_ni,
    input  logic [N_SHR-1:0]  sel66_i,
    input  logic [N_PCI-1:0]  pci_en_i,
    input  logic [N_FREE-1:0] pci_free_i,
    input  logic [N_SHR-1:0]  shr_en_i,
    input  logic              pcif_en_i,
    output logic [N_PCI-1:0]  pci_clk_o,
    output logic [N_SHR-1:0]  shr_clk_o,
    output logic              pcif_clk_o
);

    logic [N_PCI-1:0] pci_req, pci_gate;
    logic [N_SHR-1:0] shr_req, shr_gate, shr_src;
    logic             pcif_req, pcif_gate;

    pcg_req_map #(
        .N_PCI     (N_PCI),
        .N_SHR     (N_SHR),
        .FREE_BASE (FREE_BASE),
        .N_FREE    (N_FREE)
    ) u_map (
        .stop_strap_i (stop_strap_i),
        .stop_ni      (stop_ni),
        .sel66_i      (sel66_i),
        .pci_en_i     (pci_en_i),
        .pci_free_i   (pci_free_i),
        .shr_en_i     (shr_en_i),
        .pcif_en_i    (pcif_en_i),
        .pci_req_o    (pci_req),
        .shr_req_o    (shr_req),
        .pcif_req_o   (pcif_req)
    );

    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        pcg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .src_clk_i (clk_33_i),
            .rst_ni    (rst_ni),
            .run_req_i (pci_req[i]),
            .gate_o    (pci_gate[i]),
            .clk_o     (pci_clk_o[i])
        );
    end

    for (genvar j = 0; j < N_SHR; j++) begin : g_shr
        assign shr_src[j] = (pcg_src_e'(sel66_i[j]) == SRC_66) ? clk_66_i : clk_33_i;
        pcg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .src_clk_i (shr_src[j]),
            .rst_ni    (rst_ni),
            .run_req_i (shr_req[j]),
            .gate_o    (shr_gate[j]),
            .clk_o     (shr_clk_o[j])
        );
    end

    pcg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_free (
        .src_clk_i (clk_33_i),
        .rst_ni    (rst_ni),
        .run_req_i (pcif_req),
        .gate_o    (pcif_gate),
        .clk_o     (pcif_clk_o)
    );

endmodule

// File: rtl/pcg_clock_gater_chk.sv
module pcg_clock_gater_chk
    import pcg_pkg::*;
#(
    parameter int unsigned N_PCI     = 8,
    parameter int unsigned N_SHR     = 4,
    parameter int unsigned FREE_BASE = 3,
    parameter int unsigned N_FREE    = 3
) (
    input logic              clk_33_i,
    input logic              rst_ni,
    input logic              stop_strap_i,
    input logic              stop_ni,
    input logic [N_SHR-1:0]  sel66_i,
    input logic [N_PCI-1:0]  pci_en_i,
    input logic [N_FREE-1:0] pci_free_i,
    input logic [N_SHR-1:0]  shr_en_i,
    input logic              pcif_en_i,
    input logic [N_PCI-1:0]  pci_gate,
    input logic [N_SHR-1:0]  shr_gate,
    input logic [N_SHR-1:0]  shr_src,
    input logic              pcif_gate
);

    // Rising edges of clk_33 seen since reset, saturating at 3.
    logic [1:0] age_q;
    always_ff @(posedge clk_33_i or negedge rst_ni) begin
        if (!rst_ni)           age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    logic             old;
    logic [N_PCI-1:0] held;
    assign old = (age_q == 2'd3);

    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        if (pcg_in_window(i, FREE_BASE, N_FREE)) begin : g_w
            assign held[i] = stop_strap_i & ~stop_ni & ~pci_free_i[i - FREE_BASE];
        end else begin : g_n
            assign held[i] = stop_strap_i & ~stop_ni;
        end

        a_r6_pci_disabled: assert property (@(posedge clk_33_i) disable iff (!rst_ni)
            (old && !pci_en_i[i] && $past(!pci_en_i[i]) && $past(!pci_en_i[i], 2)) |-> !pci_gate[i]);

        // R2 and R5: a steady, non-immune stop closes the gate.
        a_r2_pci_stopped: assert property (@(posedge clk_33_i) disable iff (!rst_ni)
            (old && held[i] && $past(held[i]) && $past(held[i], 2)) |-> !pci_gate[i]);

        a_r7_pci_no_strap: assert property (@(posedge clk_33_i) disable iff (!rst_ni)
            (old && !stop_strap_i && $past(!stop_strap_i) && $past(!stop_strap_i, 2)
                 && pci_en_i[i] && $past(pci_en_i[i]) && $past(pci_en_i[i], 2)) |-> pci_gate[i]);

        always @(pci_gate[i]) begin
            if (rst_ni) a_r8_pci_low_edge: assert (!clk_33_i);
        end
    end

    for (genvar j = 0; j < N_SHR; j++) begin : g_shr
        a_r4_fast_runs: assert property (@(posedge clk_33_i) disable iff (!rst_ni)
            (old && sel66_i[j] && shr_en_i[j] && $past(shr_en_i[j]) && $past(shr_en_i[j], 2))
                |-> shr_gate[j]);

        a_r6_shr_disabled: assert property (@(posedge clk_33_i) disable iff (!rst_ni)
            (old && !shr_en_i[j] && $past(!shr_en_i[j]) && $past(!shr_en_i[j], 2)) |-> !shr_gate[j]);

        always @(shr_gate[j]) begin
            if (rst_ni) a_r8_shr_low_edge: assert (!shr_src[j]);
        end
    end

    a_r3_free_runs: assert property (@(posedge clk_33_i) disable iff (!rst_ni)
        (old && pcif_en_i && $past(pcif_en_i) && $past(pcif_en_i, 2)) |-> pcif_gate);

    always @(pcif_gate) begin
        if (rst_ni) a_r8_free_low_edge: assert (!clk_33_i);
    end

endmodule

bind pcg_clock_gater pcg_clock_gater_chk #(
    .N_PCI     (N_PCI),
    .N_SHR     (N_SHR),
    .FREE_BASE (FREE_BASE),
    .N_FREE    (N_FREE)
) u_chk (
    .clk_33_i     (clk_33_i),
    .rst_ni       (rst_ni),
    .stop_strap_i (stop_strap_i),
    .stop_ni      (stop_ni),
    .sel66_i      (sel66_i),
    .pci_en_i     (pci_en_i),
    .pci_free_i   (pci_free_i),
    .shr_en_i     (shr_en_i),
    .pcif_en_i    (pcif_en_i),
    .pci_gate     (pci_gate),
    .shr_gate     (shr_gate),
    .shr_src      (shr_src),
    .pcif_gate    (pcif_gate)
);

// File: tb/sim_pcg_clock_gater.sv
`timescale 1ns/100ps
module sim_pcg_clock_gater;

    localparam int unsigned NP = 8;
    localparam int unsigned NS = 4;
    localparam int unsigned FB = 3;
    localparam int unsigned NF = 3;
    localparam logic [NS-1:0] SEL66 = 4'b0101;
    localparam int NOUT = NP + NS + 1;

    typedef struct packed {
        logic          strap;
        logic          stop_n;
        logic          fen;
        logic [NS-1:0] sen;
        logic [NF-1:0] free;
        logic [NP-1:0] pen;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 4'hF, 3'b000, 8'hFF},
        {1'b1, 1'b0, 1'b1, 4'hF, 3'b000, 8'hFF},
        {1'b1, 1'b0, 1'b1, 4'hF, 3'b101, 8'hFF},
        {1'b1, 1'b0, 1'b1, 4'hF, 3'b010, 8'hFF},
        {1'b0, 1'b0, 1'b1, 4'hF, 3'b000, 8'hFF},
        {1'b0, 1'b1, 1'b0, 4'h3, 3'b000, 8'hA5},
        {1'b1, 1'b0, 1'b1, 4'hE, 3'b111, 8'h0F},
        {1'b1, 1'b0, 1'b1, 4'h0, 3'b000, 8'h00},
        {1'b1, 1'b1, 1'b1, 4'hF, 3'b000, 8'hFF}
    };
    localparam string VTAG [NV] = '{"R2", "R2", "R5", "R5", "R7", "R6", "R6", "R3", "R2"};

    logic clk_66 = 1'b0;
    logic clk_33 = 1'b0;
    logic rst_n  = 1'b0;
    logic          strap, stop_n, fen;
    logic [NS-1:0] sen;
    logic [NF-1:0] free;
    logic [NP-1:0] pen;
    logic [NP-1:0] pci_o;
    logic [NS-1:0] shr_o;
    logic          pf_o;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk_66 = ~clk_66;
    always @(posedge clk_66) clk_33 <= ~clk_33;

    pcg_clock_gater #(
        .N_PCI(NP), .N_SHR(NS), .FREE_BASE(FB), .N_FREE(NF), .SYNC_STAGES(2)
    ) u0 (
        .clk_33_i (clk_33), .clk_66_i (clk_66), .rst_ni (rst_n),
        .stop_strap_i (strap), .stop_ni (stop_n), .sel66_i (SEL66),
        .pci_en_i (pen), .pci_free_i (free), .shr_en_i (sen), .pcif_en_i (fen),
        .pci_clk_o (pci_o), .shr_clk_o (shr_o), .pcif_clk_o (pf_o)
    );

    // Pulse-width monitor (R8): every high pulse is a full half period.
    wire [NOUT-1:0] obs = {pf_o, shr_o, pci_o};
    time rise_t [NOUT];
    int  runt_n [NOUT];
    for (genvar k = 0; k < NOUT; k++) begin : g_mon
        localparam time HALF = (k >= NP && k < NP + NS && SEL66[(k - NP) % NS]) ? 2 : 4;
        initial begin rise_t[k] = 0; runt_n[k] = 0; end
        always @(posedge obs[k]) rise_t[k] = $time;
        always @(negedge obs[k]) if (rst_n && ($time - rise_t[k] != HALF)) runt_n[k]++;
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected run pattern from the requirements.
    function automatic logic [NOUT-1:0] expect_run(vec_t v);
        logic stop_act = v.strap & ~v.stop_n;
        logic [NOUT-1:0] r;
        for (int i = 0; i < NP; i++) begin
            logic imm = (i >= FB && i < FB + NF) ? v.free[i - FB] : 1'b0;
            r[i] = v.pen[i] & ~(stop_act & ~imm);
        end
        for (int j = 0; j < NS; j++) r[NP + j] = v.sen[j] & ~(stop_act & ~SEL66[j]);
        r[NOUT-1] = v.fen;
        return r;
    endfunction

    task automatic apply(vec_t v);
        strap = v.strap; stop_n = v.stop_n; fen = v.fen;
        sen = v.sen; free = v.free; pen = v.pen;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [NOUT-1:0] e;
        int runts;
        apply(VEC[0]);
        // R1: all outputs low during reset, in both phase samples.
        repeat (3) @(posedge clk_33);
        #1 check("R1 reset high phase", 16'(obs), 16'h0);
        #4 check("R1 reset low phase", 16'(obs), 16'h0);
        @(negedge clk_33);
        #1 rst_n = 1'b1;
        @(posedge clk_33);
        #1 check("R1 first phase after release", 16'(obs), 16'h0);
        @(posedge clk_33);
        #1 check("R1 second phase after release", 16'(pci_o), 16'h0);
        @(posedge clk_33);
        #1 check("R1 third phase running", 16'(obs), 16'(expect_run(VEC[0])));

        for (int v = 0; v < NV; v++) begin
            @(posedge clk_33);
            #2.5 apply(VEC[v]);
            repeat (4) @(posedge clk_33);
            e = expect_run(VEC[v]);
            #1 check({VTAG[v], " both sources high"}, 16'(obs), 16'(e));
            // clk_33 low, clk_66 high: only 66 MHz shared outputs may be high (R4).
            #4 check({VTAG[v], " R4 fast phase"}, 16'(obs),
                     16'({1'b0, e[NP +: NS] & SEL66, {NP{1'b0}}}));
        end

        repeat (2) @(posedge clk_33);
        runts = 0;
        for (int k = 0; k < NOUT; k++) runts += runt_n[k];
        check("R8 runt pulses", 16'(runts), 16'h0);
        finish_run();
    end

endmodule